// File: doc/BRIEF.md
# Posted Interrupt Counter Bank

This block sits between a broadcast register-write path and a small group of local processors. I/O slots post interrupts by writing a post word. The word names the priority levels being raised and the virtual node IDs being targeted. For every local processor whose node ID is addressed and whose level mask allows the level, the block counts one more outstanding interrupt for that processor, source slot and level. The processor then sees a request line for that level.

Each count falls by one when the processor reads the vector register of that slot at that level. The processor can read a 32-bit summary word at any time. The word shows which slot/level pairs still have work, which levels have any work at all, and whether an interprocessor interrupt is waiting. Interprocessor posts carry one bit per node ID. Each processor takes the bit that matches its own ID, and only does so when its interprocessor enable is set. It clears the resulting flag by writing a one.

The defaults give two processors, five slots and four levels. Levels 0 to 2 stand for priorities 0x14 to 0x16 and level 3 stands for 0x17.

Top module: `irq_count_bank`

## Requirements
- R1: A post (post_valid high) is accepted by processor c at level l when post_word bit (cpu_vid of c) in bits 15:0 is one, post_word bit 16+l is one, and cpu_lvl_en bit l of c is one. The counter for (c, post_slot, l) then rises by one, and summary bit 7+4*slot+l of c reads one on the cycle after the post.
- R2: A post whose node-ID bit is zero for a processor, or whose level is masked off in that processor's cpu_lvl_en, leaves that processor's summary unchanged.
- R3: Counters at levels 0, 1 and 2 saturate at 4, and level-3 counters saturate at 5. A post accepted at the limit is dropped without wrapping.
- R4: An ack (ack_valid of c, with ack_slot and ack_lvl) lowers the counter for that triple by one. A counter at zero stays at zero.
- R5: An accepted post and an ack on the same counter in the same cycle leave its value unchanged.
- R6: Summary bit 1+l is the OR of the nonzero flags of all slots at level l, and irq_req bit 4*c+l equals summary bit 1+l of processor c.
- R7: An interprocessor post (ipi_valid) with ipi_vids bit (cpu_vid of c) set sets processor c's pending flag, shown in summary bit 0, if and only if cpu_ip_en of c is one.
- R8: ipi_clr of c clears that pending flag on the next cycle. A set in the same cycle wins over the clear.
- R9: A post_slot or ack_slot of 5 or more has no effect.
- R10: rst, which is synchronous and active high, clears every counter and flag, so summary and irq_req read zero.
- R11: A single post may raise several levels and reach several processors at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Interrupt post strobe |
| post_slot | input | 3 | Index of the posting I/O slot |
| post_word | input | 20 | Bits 19:16 hold the level set; bits 15:0 hold the node-ID set |
| cpu_vid | input | 8 | 4-bit node ID per processor, processor 0 in the low nibble |
| cpu_lvl_en | input | 8 | 4-bit level enable per processor |
| cpu_ip_en | input | 2 | Interprocessor enable per processor |
| ack_valid | input | 2 | Vector-read strobe per processor |
| ack_slot | input | 6 | 3-bit slot of the vector read per processor |
| ack_lvl | input | 4 | 2-bit level of the vector read per processor |
| ipi_valid | input | 1 | Interprocessor post strobe |
| ipi_vids | input | 16 | One bit per target node ID |
| ipi_clr | input | 2 | Write-one-to-clear of the pending flag per processor |
| summary | output | 64 | 32-bit summary word per processor |
| irq_req | output | 8 | 4 level requests per processor |

## Verification
Every result of this block comes from a state register, so it appears exactly one rising edge after the post, ack, interprocessor write, clear or reset that caused it. The bench applies each stimulus after a falling edge and holds it across one rising edge. It then compares summary and irq_req at the next falling edge, so each value is read in the first cycle it is due. The saturation depths are found by counting acks: a counter that drops to zero after exactly N acks, but not after N-1, must have held N.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int SUM_W         = 32;
  localparam int SUM_IPI_BIT   = 0;
  localparam int SUM_LVL_BASE  = 1;
  localparam int SUM_PAIR_BASE = 7;

  function automatic int depth_for(int lvl, int nlvl, int low_d, int top_d);
    return (lvl == nlvl - 1) ? top_d : low_d;
  endfunction
endpackage

// File: rtl/irq_sat_counter.sv
module irq_sat_counter #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic nz
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (inc && !dec && cnt_q != W'(MAX))
      cnt_q <= cnt_q + W'(1);
    else if (dec && !inc && cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign nz = |cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(MAX));
  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == W'(MAX) && inc && !dec) |=> cnt_q == W'(MAX));
  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && dec && !inc) |=> cnt_q == '0);
  assert_both_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int NUM_LVLS  = 4,
  parameter int VID_W     = 4,
  parameter int SLOT_W    = 3,
  parameter int LVL_W     = 2,
  parameter int LOW_DEPTH = 4,
  parameter int TOP_DEPTH = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    post_valid,
  input  logic [SLOT_W-1:0]       post_slot,
  input  logic [NUM_LVLS-1:0]     post_lvls,
  input  logic [(1<<VID_W)-1:0]   post_vids,
  input  logic [VID_W-1:0]        my_vid,
  input  logic [NUM_LVLS-1:0]     lvl_en,
  input  logic                    ip_en,
  input  logic                    ack_valid,
  input  logic [SLOT_W-1:0]       ack_slot,
  input  logic [LVL_W-1:0]        ack_lvl,
  input  logic                    ipi_valid,
  input  logic [(1<<VID_W)-1:0]   ipi_vids,
  input  logic                    ipi_clr,
  output logic [SUM_W-1:0]        summary,
  output logic [NUM_LVLS-1:0]     irq_req
);
  localparam int NPAIR = NUM_SLOTS * NUM_LVLS;

  logic [NPAIR-1:0]    nz;
  logic [NUM_LVLS-1:0] lvl_any;
  logic                vid_hit;
  logic                ipi_set;
  logic                ip_q;

  assign vid_hit = post_vids[my_vid];
  assign ipi_set = ipi_valid && ipi_vids[my_vid] && ip_en;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar l = 0; l < NUM_LVLS; l++) begin : g_lvl
      logic inc, dec;
      assign inc = post_valid && vid_hit && (post_slot == SLOT_W'(s))
                   && post_lvls[l] && lvl_en[l];
      assign dec = ack_valid && (ack_slot == SLOT_W'(s)) && (ack_lvl == LVL_W'(l));
      irq_sat_counter #(
        .MAX(depth_for(l, NUM_LVLS, LOW_DEPTH, TOP_DEPTH))
      ) u_cnt (
        .clk(clk), .rst(rst), .inc(inc), .dec(dec), .nz(nz[s*NUM_LVLS+l])
      );
      assert_req_follows_R6: assert property (@(posedge clk) disable iff (rst)
        nz[s*NUM_LVLS+l] |-> irq_req[l]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ip_q <= 1'b0;
    else if (ipi_set) ip_q <= 1'b1;
    else if (ipi_clr) ip_q <= 1'b0;
  end

  always_comb begin
    lvl_any = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int l = 0; l < NUM_LVLS; l++)
        lvl_any[l] = lvl_any[l] | nz[s*NUM_LVLS+l];
  end

  always_comb begin
    summary = '0;
    summary[SUM_IPI_BIT] = ip_q;
    for (int l = 0; l < NUM_LVLS; l++)
      summary[SUM_LVL_BASE+l] = lvl_any[l];
    for (int p = 0; p < NPAIR; p++)
      summary[SUM_PAIR_BASE+p] = nz[p];
  end

  assign irq_req = lvl_any;

  assert_ipi_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ipi_valid && ipi_vids[my_vid] && ip_en) |=> summary[SUM_IPI_BIT]);
  assert_ipi_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (ipi_clr && !(ipi_valid && ipi_vids[my_vid] && ip_en)) |=> !summary[SUM_IPI_BIT]);
  assert_unaddressed_R2: assert property (@(posedge clk) disable iff (rst)
    (post_valid && !post_vids[my_vid] && !ack_valid) |=> $stable(summary[SUM_W-1:SUM_PAIR_BASE]));
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (summary == '0));
endmodule

// File: rtl/irq_count_bank.sv
module irq_count_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_SLOTS = 5,
  parameter int NUM_LVLS  = 4,
  parameter int VID_W     = 4,
  parameter int SLOT_W    = 3,
  parameter int LOW_DEPTH = 4,
  parameter int TOP_DEPTH = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              post_valid,
  input  logic [SLOT_W-1:0]                 post_slot,
  input  logic [(1<<VID_W)+NUM_LVLS-1:0]    post_word,
  input  logic [NUM_CPUS*VID_W-1:0]         cpu_vid,
  input  logic [NUM_CPUS*NUM_LVLS-1:0]      cpu_lvl_en,
  input  logic [NUM_CPUS-1:0]               cpu_ip_en,
  input  logic [NUM_CPUS-1:0]               ack_valid,
  input  logic [NUM_CPUS*SLOT_W-1:0]        ack_slot,
  input  logic [NUM_CPUS*$clog2(NUM_LVLS)-1:0] ack_lvl,
  input  logic                              ipi_valid,
  input  logic [(1<<VID_W)-1:0]             ipi_vids,
  input  logic [NUM_CPUS-1:0]               ipi_clr,
  output logic [NUM_CPUS*SUM_W-1:0]         summary,
  output logic [NUM_CPUS*NUM_LVLS-1:0]      irq_req
);
  localparam int NVID  = 1 << VID_W;
  localparam int LVL_W = $clog2(NUM_LVLS);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_bank #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_LVLS(NUM_LVLS), .VID_W(VID_W),
      .SLOT_W(SLOT_W), .LVL_W(LVL_W),
      .LOW_DEPTH(LOW_DEPTH), .TOP_DEPTH(TOP_DEPTH)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .post_valid(post_valid),
      .post_slot (post_slot),
      .post_lvls (post_word[NVID +: NUM_LVLS]),
      .post_vids (post_word[NVID-1:0]),
      .my_vid    (cpu_vid[c*VID_W +: VID_W]),
      .lvl_en    (cpu_lvl_en[c*NUM_LVLS +: NUM_LVLS]),
      .ip_en     (cpu_ip_en[c]),
      .ack_valid (ack_valid[c]),
      .ack_slot  (ack_slot[c*SLOT_W +: SLOT_W]),
      .ack_lvl   (ack_lvl[c*LVL_W +: LVL_W]),
      .ipi_valid (ipi_valid),
      .ipi_vids  (ipi_vids),
      .ipi_clr   (ipi_clr[c]),
      .summary   (summary[c*SUM_W +: SUM_W]),
      .irq_req   (irq_req[c*NUM_LVLS +: NUM_LVLS])
    );
  end
endmodule

// File: tb/tb_irq_count_bank.sv
module tb_irq_count_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        post_valid;
  logic [2:0]  post_slot;
  logic [19:0] post_word;
  logic [7:0]  cpu_vid;
  logic [7:0]  cpu_lvl_en;
  logic [1:0]  cpu_ip_en;
  logic [1:0]  ack_valid;
  logic [5:0]  ack_slot;
  logic [3:0]  ack_lvl;
  logic        ipi_valid;
  logic [15:0] ipi_vids;
  logic [1:0]  ipi_clr;
  logic [63:0] summary;
  logic [7:0]  irq_req;

  int checks = 0;
  int fails  = 0;

  irq_count_bank dut (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_slot(post_slot),
    .post_word(post_word), .cpu_vid(cpu_vid), .cpu_lvl_en(cpu_lvl_en),
    .cpu_ip_en(cpu_ip_en), .ack_valid(ack_valid), .ack_slot(ack_slot),
    .ack_lvl(ack_lvl), .ipi_valid(ipi_valid), .ipi_vids(ipi_vids),
    .ipi_clr(ipi_clr), .summary(summary), .irq_req(irq_req)
  );

  always #2 clk = ~clk;

  // {slot, levels, vids, expected summary cpu0, expected summary cpu1}
  localparam logic [86:0] VEC [6] = '{
    {3'd0, 4'b0001, 16'h0004, 32'h0000_0082, 32'h0000_0000},  // R1
    {3'd1, 4'b0100, 16'h0200, 32'h0000_0082, 32'h0000_2008},  // R1
    {3'd4, 4'b1010, 16'h0204, 32'h0500_0096, 32'h0000_2008},  // R11 R2
    {3'd2, 4'b1111, 16'h0020, 32'h0500_0096, 32'h0000_2008},  // R2
    {3'd7, 4'b0001, 16'h0004, 32'h0500_0096, 32'h0000_2008},  // R9
    {3'd3, 4'b0001, 16'h0200, 32'h0500_0096, 32'h0008_200A}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic post(input logic [2:0] s, input logic [3:0] l, input logic [15:0] v);
    post_valid = 1'b1; post_slot = s; post_word = {l, v};
    step();
    post_valid = 1'b0;
  endtask

  task automatic ack(input int c, input logic [2:0] s, input logic [1:0] l);
    ack_valid[c] = 1'b1; ack_slot[c*3 +: 3] = s; ack_lvl[c*2 +: 2] = l;
    step();
    ack_valid = '0;
  endtask

  function automatic int pbit(input int s, input int l);
    return 7 + 4 * s + l;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; post_valid = 1'b0; post_slot = '0; post_word = '0;
    cpu_vid = {4'd9, 4'd2}; cpu_lvl_en = {4'b0101, 4'b1111}; cpu_ip_en = 2'b01;
    ack_valid = '0; ack_slot = '0; ack_lvl = '0;
    ipi_valid = 1'b0; ipi_vids = '0; ipi_clr = '0;
    @(negedge clk); step();
    rst = 1'b0;
    check("R10 reset summary", summary[31:0] | summary[63:32], 32'h0);
    check("R10 reset irq_req", {24'h0, irq_req}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      post(VEC[i][86:84], VEC[i][83:80], VEC[i][79:64]);
      check($sformatf("R1 vector %0d cpu0", i), summary[31:0], VEC[i][63:32]);
      check($sformatf("R1 vector %0d cpu1", i), summary[63:32], VEC[i][31:0]);
      check($sformatf("R6 vector %0d req", i), {24'h0, irq_req},
            {24'h0, summary[36:33], summary[4:1]});
    end

    // R3 level 3 holds five
    for (int i = 0; i < 6; i++) post(3'd0, 4'b1000, 16'h0004);
    for (int i = 0; i < 4; i++) ack(0, 3'd0, 2'd3);
    check("R3 top level after 4 acks", {31'h0, summary[pbit(0,3)]}, 32'h1);
    ack(0, 3'd0, 2'd3);
    check("R3 top level after 5 acks", {31'h0, summary[pbit(0,3)]}, 32'h0);
    check("R6 level3 other slot", {31'h0, irq_req[3]}, 32'h1);

    // R3 low level holds four
    for (int i = 0; i < 5; i++) post(3'd0, 4'b0001, 16'h0004);
    for (int i = 0; i < 3; i++) ack(0, 3'd0, 2'd0);
    check("R3 low level after 3 acks", {31'h0, summary[pbit(0,0)]}, 32'h1);
    ack(0, 3'd0, 2'd0);
    check("R3 low level after 4 acks", {31'h0, summary[pbit(0,0)]}, 32'h0);
    check("R6 level0 drops", {31'h0, irq_req[0]}, 32'h0);

    // R4 decrement at zero
    ack(0, 3'd0, 2'd0);
    ack(0, 3'd0, 2'd0);
    post(3'd0, 4'b0001, 16'h0004);
    check("R4 post after zero acks", {31'h0, summary[pbit(0,0)]}, 32'h1);
    ack(0, 3'd0, 2'd0);
    check("R4 single ack clears", {31'h0, summary[pbit(0,0)]}, 32'h0);

    // R5 simultaneous increment and decrement
    post(3'd0, 4'b0001, 16'h0004);
    post_valid = 1'b1; post_slot = 3'd0; post_word = {4'b0001, 16'h0004};
    ack_valid[0] = 1'b1; ack_slot[2:0] = 3'd0; ack_lvl[1:0] = 2'd0;
    step();
    post_valid = 1'b0; ack_valid = '0;
    check("R5 both same cycle", {31'h0, summary[pbit(0,0)]}, 32'h1);
    ack(0, 3'd0, 2'd0);
    check("R5 one ack clears", {31'h0, summary[pbit(0,0)]}, 32'h0);

    // R9 out-of-range ack slot
    ack(0, 3'd5, 2'd1);
    ack(0, 3'd7, 2'd1);
    check("R9 bad ack slot", {31'h0, summary[pbit(4,1)]}, 32'h1);

    // R11 one post to both processors
    post(3'd2, 4'b0001, 16'h0204);
    check("R11 cpu0", {31'h0, summary[pbit(2,0)]}, 32'h1);
    check("R11 cpu1", {31'h0, summary[32 + pbit(2,0)]}, 32'h1);

    // R2 masked level
    post(3'd2, 4'b0010, 16'h0200);
    check("R2 masked level cpu1", {31'h0, summary[32 + pbit(2,1)]}, 32'h0);

    // R7 interprocessor posts
    ipi_valid = 1'b1; ipi_vids = 16'h0204;
    step();
    ipi_valid = 1'b0;
    check("R7 cpu0 enabled", {31'h0, summary[0]}, 32'h1);
    check("R7 cpu1 disabled", {31'h0, summary[32]}, 32'h0);

    // R8 clear and set priority
    ipi_clr = 2'b01; step(); ipi_clr = '0;
    check("R8 clear", {31'h0, summary[0]}, 32'h0);
    ipi_valid = 1'b1; ipi_vids = 16'h0004; ipi_clr = 2'b01;
    step();
    ipi_valid = 1'b0; ipi_clr = '0;
    check("R8 set wins", {31'h0, summary[0]}, 32'h1);

    // R10 mid-run reset
    rst = 1'b1; step(); rst = 1'b0;
    check("R10 mid reset cpu0", summary[31:0], 32'h0);
    check("R10 mid reset cpu1", summary[63:32], 32'h0);
    check("R10 mid reset req", {24'h0, irq_req}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule